// File: doc/BRIEF.md
# Mode Request Validation Status Unit

This unit checks every request to move the device into a new operating mode. Each request is a one-cycle strobe with a 4-bit target mode code. The unit tests the request against five conditions:

- whether a transition is already in progress;
- whether the move is allowed by a fixed legality rule;
- whether the target mode exists;
- whether the target mode is enabled;
- whether a SAFE event is pending while the device sits in SAFE mode.

Every condition that holds sets its own sticky flag. One bad request can therefore raise several flags at once. A request is accepted only when no condition holds, and the accept signal is given in the same cycle as the request.

Software reads the flags through a small register port and clears them by writing ones. Only supervisor accesses take effect. An interrupt line is raised while any flag is set whose mask bit is also set. The reset input is asserted asynchronously and released synchronously on the clock inside the unit, two clock edges after it rises.

Top module: `mode_req_check`

## Requirements
- R1: After reset all five flags are zero. A supervisor read of the status address returns 0 and `irq` is low.
- R2: The status register is read at word address 0x5 on the 4-bit bus address. The flags sit at these bits: SAFE-event-active bit 0, non-existing-mode bit 1, disabled-mode bit 2, request-illegal bit 3, transition-illegal bit 4. Bits 31:5 read as 0, and a read of any other address returns 0.
- R3: A supervisor write to the status address clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: With `bus_super` low, a read returns 0 and a write changes no flag.
- R5: A request made while `xfer_busy` is high sets bit 4.
- R6: A request sets bit 3 when the move is not legal. A move is legal when the target code is not 0 (RESET) and the current and target codes do not both have bit 3 set.
- R7: A request sets bit 2 when the target mode exists but its bit in `mode_en` is 0.
- R8: A request sets bit 1 when the target's bit in `mode_exist` is 0.
- R9: A request sets bit 0 when `cur_mode` is SAFE (code 2), `safe_pend` is high, and the target is neither 0 nor 2.
- R10: `req_accept` is high in the cycle of a request exactly when none of the conditions in R5 to R9 holds. It is low when there is no request.
- R11: When a request sets a flag in the same cycle that a write clears it, the flag ends up set.
- R12: `irq` is high exactly when some flag is set whose bit in `irq_mask` is also set.
- R13: Flags are sticky. They stay set through later valid requests until they are cleared, and one request can set several flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 4 | Requested target mode code |
| cur_mode | input | 4 | Current mode code |
| xfer_busy | input | 1 | A mode transition is in progress |
| mode_en | input | 16 | Per-mode enable bits |
| mode_exist | input | 16 | Per-mode existence bits |
| safe_pend | input | 1 | A SAFE event is pending |
| irq_mask | input | 5 | Interrupt mask, one bit per flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write |
| bus_super | input | 1 | Access is made in supervisor mode |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data; ones clear flags |
| bus_rdata | output | 32 | Read data, combinational |
| req_accept | output | 1 | Request accepted in this cycle |
| irq | output | 1 | Invalid-mode interrupt |

## Verification
Each result is due at a known point relative to the request:

- `req_accept` and `bus_rdata` are combinational. The bench checks them 1 ns after it drives the inputs at the falling edge, in the same cycle.
- A flag set by a request, or cleared by a write, changes at the next rising edge. The bench therefore reads the status register at the following falling edge and checks `irq` in that same cycle.

The sweep covers every current/target pair under four settings of the enable and existence vectors, the busy flag and the pending flag. After each request it clears all flags, so every expected value depends on that one request alone.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int MODE_W  = 4;
  localparam int NMODES  = 1 << MODE_W;
  localparam int NCAUSE  = 5;

  localparam logic [MODE_W-1:0] MODE_RESET = 4'h0;
  localparam logic [MODE_W-1:0] MODE_SAFE  = 4'h2;

  // flag positions, decoded by software
  localparam int F_SAFE_EVT = 0;
  localparam int F_NO_MODE  = 1;
  localparam int F_DISABLED = 2;
  localparam int F_BAD_MOVE = 3;
  localparam int F_BUSY     = 4;

  // legal move: target is not RESET and not low-power to low-power
  function automatic logic legal_move(logic [MODE_W-1:0] cur, logic [MODE_W-1:0] tgt);
    return (tgt != MODE_RESET) && !(cur[MODE_W-1] && tgt[MODE_W-1]);
  endfunction
endpackage

// File: rtl/mrc_rst_sync.sv
module mrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mrc_cause_eval.sv
module mrc_cause_eval
  import mrc_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int NM = 1 << MW
) (
  input  logic              req_valid,
  input  logic [MW-1:0]     req_mode,
  input  logic [MW-1:0]     cur_mode,
  input  logic              xfer_busy,
  input  logic [NM-1:0]     mode_en,
  input  logic [NM-1:0]     mode_exist,
  input  logic              safe_pend,
  output logic [NCAUSE-1:0] cause,
  output logic              accept
);
  logic tgt_exists;
  logic tgt_enabled;
  logic tgt_escape;

  always_comb begin
    tgt_exists  = mode_exist[req_mode];
    tgt_enabled = mode_en[req_mode];
    tgt_escape  = (req_mode == MODE_RESET) || (req_mode == MODE_SAFE);

    cause             = '0;
    cause[F_BUSY]     = req_valid && xfer_busy;
    cause[F_BAD_MOVE] = req_valid && !legal_move(cur_mode, req_mode);
    cause[F_DISABLED] = req_valid && tgt_exists && !tgt_enabled;
    cause[F_NO_MODE]  = req_valid && !tgt_exists;
    cause[F_SAFE_EVT] = req_valid && (cur_mode == MODE_SAFE) && safe_pend && !tgt_escape;

    accept = req_valid && (cause == '0);
  end
endmodule

// File: rtl/mrc_status_reg.sv
module mrc_status_reg
  import mrc_pkg::*;
#(
  parameter int N = NCAUSE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    // a hardware set overrides a software clear
    always_comb begin
      flag_en = set_i[i] || clr_i[i];
      flag_d  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/mrc_bus_port.sv
module mrc_bus_port
  import mrc_pkg::*;
#(
  parameter int                DW   = 32,
  parameter int                AW   = 4,
  parameter logic [AW-1:0]     ADDR = 4'h5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_super,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NCAUSE-1:0] flags,
  output logic [NCAUSE-1:0] clr,
  output logic [DW-1:0]     bus_rdata
);
  localparam int PAD_W = DW - NCAUSE;

  logic hit;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:NCAUSE];

  always_comb begin
    hit       = bus_sel && bus_super && (bus_addr == ADDR);
    clr       = (hit && bus_wr) ? bus_wdata[NCAUSE-1:0] : '0;
    bus_rdata = (hit && !bus_wr) ? {{PAD_W{1'b0}}, flags} : '0;
  end
endmodule

// File: rtl/mode_req_check.sv
module mode_req_check
  import mrc_pkg::*;
#(
  parameter int            DATA_W      = 32,
  parameter int            ADDR_W      = 4,
  parameter logic [3:0]    STATUS_ADDR = 4'h5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [MODE_W-1:0]   req_mode,
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic                xfer_busy,
  input  logic [NMODES-1:0]   mode_en,
  input  logic [NMODES-1:0]   mode_exist,
  input  logic                safe_pend,
  input  logic [NCAUSE-1:0]   irq_mask,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_super,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                req_accept,
  output logic                irq
);
  logic              rst_sync_n;
  logic [NCAUSE-1:0] cause;
  logic [NCAUSE-1:0] clr;
  logic [NCAUSE-1:0] flags;

  mrc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mrc_cause_eval #(.MW(MODE_W), .NM(NMODES)) u_eval (
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .cur_mode   (cur_mode),
    .xfer_busy  (xfer_busy),
    .mode_en    (mode_en),
    .mode_exist (mode_exist),
    .safe_pend  (safe_pend),
    .cause      (cause),
    .accept     (req_accept)
  );

  mrc_status_reg #(.N(NCAUSE)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (cause),
    .clr_i   (clr),
    .flags_o (flags)
  );

  mrc_bus_port #(.DW(DATA_W), .AW(ADDR_W), .ADDR(STATUS_ADDR)) u_bus (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_super (bus_super),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags),
    .clr       (clr),
    .bus_rdata (bus_rdata)
  );

  assign irq = |(flags & irq_mask);
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker
  import mrc_pkg::*;
#(
  parameter int         DATA_W      = 32,
  parameter int         ADDR_W      = 4,
  parameter logic [3:0] STATUS_ADDR = 4'h5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [MODE_W-1:0]   req_mode,
  input logic                xfer_busy,
  input logic [NMODES-1:0]   mode_exist,
  input logic                req_accept,
  input logic [NCAUSE-1:0]   flags,
  input logic                irq,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic                bus_super,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata
);
  logic [NCAUSE-1:0] sw_clear;
  assign sw_clear = (bus_sel && bus_wr && bus_super && bus_addr == STATUS_ADDR)
                    ? bus_wdata[NCAUSE-1:0] : '0;

  assert_busy_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xfer_busy |=> flags[F_BUSY]);

  assert_missing_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mode_exist[req_mode] |=> flags[F_NO_MODE]);

  assert_accept_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> req_valid && !xfer_busy && mode_exist[req_mode]);

  assert_user_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_super |-> bus_rdata == '0);

  assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~sw_clear)) == $past(flags & ~sw_clear)));

  assert_quiet_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flags == '0 |-> !irq);
endmodule

bind mode_req_check mrc_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .xfer_busy  (xfer_busy),
  .mode_exist (mode_exist),
  .req_accept (req_accept),
  .flags      (flags),
  .irq        (irq),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_super  (bus_super),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata)
);

// File: tb/mode_req_check_test.sv
`timescale 1ns/1ps
module mode_req_check_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_mode;
  logic [3:0]  cur_mode;
  logic        xfer_busy;
  logic [15:0] mode_en;
  logic [15:0] mode_exist;
  logic        safe_pend;
  logic [4:0]  irq_mask;
  logic        bus_sel;
  logic        bus_wr;
  logic        bus_super;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        req_accept;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] SADDR = 4'h5;

  always #5 clk = ~clk;

  mode_req_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .cur_mode(cur_mode), .xfer_busy(xfer_busy), .mode_en(mode_en),
    .mode_exist(mode_exist), .safe_pend(safe_pend), .irq_mask(irq_mask),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_super(bus_super),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_accept(req_accept), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_flags(logic [3:0] cur, logic [3:0] tgt,
      logic busy, logic [15:0] en, logic [15:0] ex, logic pend);
    logic [4:0] f;
    f    = '0;
    f[4] = busy;
    f[3] = (tgt == 4'd0) || (cur[3] && tgt[3]);
    f[2] = ex[tgt] && !en[tgt];
    f[1] = !ex[tgt];
    f[0] = (cur == 4'd2) && pend && (tgt != 4'd0) && (tgt != 4'd2);
    return f;
  endfunction

  task automatic idle_bus();
    bus_sel = 0; bus_wr = 0; bus_super = 1; bus_addr = SADDR; bus_wdata = '0;
  endtask

  // read at the current (negedge) point, combinational result
  task automatic read_status(output logic [31:0] val);
    bus_sel = 1; bus_wr = 0; bus_super = 1; bus_addr = SADDR;
    #1 val = bus_rdata;
  endtask

  task automatic write_status(logic [31:0] data, logic sup);
    bus_sel = 1; bus_wr = 1; bus_super = sup; bus_addr = SADDR; bus_wdata = data;
    @(posedge clk); @(negedge clk);
    idle_bus();
  endtask

  task automatic request(logic [3:0] cur, logic [3:0] tgt, logic busy,
      logic [15:0] en, logic [15:0] ex, logic pend);
    req_valid = 1; req_mode = tgt; cur_mode = cur; xfer_busy = busy;
    mode_en = en; mode_exist = ex; safe_pend = pend;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  ef;
    rst_n = 0; req_valid = 0; req_mode = '0; cur_mode = 4'd4; xfer_busy = 0;
    mode_en = '1; mode_exist = '1; safe_pend = 0; irq_mask = '1;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_status(rd);
    check("R1 reset flags", rd, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    idle_bus();

    // R10 no request -> no accept
    #1 check("R10 idle accept", {31'b0, req_accept}, 32'h0);

    // exhaustive sweep R5-R10, R12
    for (int c = 0; c < 4; c++) begin
      for (int cm = 0; cm < 16; cm++) begin
        for (int tm = 0; tm < 16; tm++) begin
          logic [15:0] ex_v, en_v;
          logic        bz, pd;
          ex_v = ~(16'h1 << (c*4+1));
          en_v = ~(16'h1 << (c*4+3));
          bz   = (c == 1);
          pd   = (c >= 2);
          ef   = expect_flags(cm[3:0], tm[3:0], bz, en_v, ex_v, pd);
          irq_mask = {cm[0], tm[3:0]};
          request(cm[3:0], tm[3:0], bz, en_v, ex_v, pd);
          #1 check("R10 accept", {31'b0, req_accept}, {31'b0, ef == 5'b0});
          @(posedge clk); @(negedge clk);
          req_valid = 0;
          read_status(rd);
          check("R5 R6 R7 R8 R9 flags", rd, {27'b0, ef});
          check("R12 irq", {31'b0, irq}, {31'b0, |(ef & irq_mask)});
          write_status(32'hFFFF_FFFF, 1'b1);
        end
      end
    end
    irq_mask = '1;

    // R13: multiple causes, sticky through a good request
    request(4'd8, 4'd9, 1'b1, 16'hFDFF, 16'hFFFF, 1'b0); // busy, bad move, disabled
    @(posedge clk); @(negedge clk);
    request(4'd4, 4'd5, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0); // clean
    #1 check("R10 clean accept", {31'b0, req_accept}, 32'h1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    read_status(rd);
    check("R13 sticky multi", rd, 32'h1C);
    check("R2 upper bits zero", {5'b0, rd[31:5]}, 32'h0);
    idle_bus();

    // R2 other address reads zero
    bus_sel = 1; bus_addr = 4'h4; #1 check("R2 other addr", bus_rdata, 32'h0);
    idle_bus();

    // R4 user read zero, user write ignored
    bus_sel = 1; bus_super = 0; #1 check("R4 user read", bus_rdata, 32'h0);
    idle_bus();
    write_status(32'h1F, 1'b0);
    read_status(rd);
    check("R4 user write ignored", rd, 32'h1C);
    idle_bus();

    // R3 write zero leaves, write one clears
    write_status(32'hFFFF_FFE0, 1'b1);
    read_status(rd);
    check("R3 write zero keeps", rd, 32'h1C);
    idle_bus();
    write_status(32'h08, 1'b1);
    read_status(rd);
    check("R3 write one clears", rd, 32'h14);
    idle_bus();

    // R11 set wins over clear; bit1 set while others cleared
    request(4'd4, 4'd5, 1'b0, 16'hFFFF, 16'hFFDF, 1'b0);
    write_status(32'h1F, 1'b1);
    req_valid = 0;
    read_status(rd);
    check("R11 set wins", rd, 32'h02);
    idle_bus();
    irq_mask = 5'b11101;
    #1 check("R12 masked irq", {31'b0, irq}, 32'h0);
    irq_mask = 5'b00010;
    #1 check("R12 unmasked irq", {31'b0, irq}, 32'h1);

    // R1 reset again clears flags
    rst_n = 0;
    @(negedge clk);
    read_status(rd);
    check("R1 reset clears", rd, 32'h0);
    idle_bus();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule